// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight hardware token flags that a left and a right processor share to coordinate software ownership of common resources. Each side has its own enable, select, write strobe, 3-bit flag address and 16-bit data path. A side reaches the flags only when its memory enable is deasserted and its flag select is asserted. On a write, bit 0 of the data carries the intent: 0 asks for the token and 1 gives it back.

Each flag tracks its holder and a waiting request from the side that does not hold it. A request made while the other side holds the token is remembered. When the holder gives the token back, a waiting request is granted in that same clock cycle. With no request waiting, the flag becomes free. Reads return the flag state as seen by the reading side, copied onto every data bit.

All state changes on the rising clock edge. Read data comes combinationally from the current state, so a write shows on the next cycle's read.

Top module: `sem_bank`

## Requirements
- R1: The bank holds eight flags that are fully independent, selected by the 3-bit address of each side.
- R2: A side reaches a flag only when its ce_n is 1 and its sel_n is 0. Any other write leaves every flag unchanged. Read data is 0xFFFF whenever the side is not doing a flag read (wr_n = 1 with access).
- R3: A write uses data bit 0 alone: 0 requests the token and 1 releases it. Bits 15..1 have no effect.
- R4: A flag read returns the same value on all 16 bits: 0x0000 when the reading side holds the token and 0xFFFF otherwise.
- R5: A request to a free flag grants the token to the requester. The grant is visible on the next cycle.
- R6: A request to a flag held by the other side leaves ownership unchanged and is recorded as waiting. A side never has a waiting request on a flag it holds.
- R7: When the holder releases and the other side has a waiting request, the other side owns the token from the next cycle.
- R8: When the holder releases and no request is waiting, the flag becomes free.
- R9: A release written by the side that does not hold the token withdraws that side's waiting request and changes nothing else.
- R10: When both sides request the same free flag in the same cycle, the left side gets the token and the right request waits.
- R11: After reset all flags are free and no request is waiting.
- R12: The two sides never hold the same flag at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left memory enable, active low (must be 1 for flag access) |
| l_sel_n | input | 1 | Left flag select, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 16 | Left write data (bit 0 used) |
| l_rdata | output | 16 | Left read data |
| r_ce_n | input | 1 | Right memory enable, active low (must be 1 for flag access) |
| r_sel_n | input | 1 | Right flag select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 16 | Right write data (bit 0 used) |
| r_rdata | output | 16 | Right read data |

## Verification
The assertions check several rules on every cycle:
- No flag is held by both sides.
- No holder also has a waiting request.
- Read data is always all zeros or all ones.
- The flags stay still when neither side writes one.
- A left request to a free flag is granted.

Only the bench's scenarios can show:
- The ordered handover sequence.
- Left priority on a simultaneous request.
- A waiting request being withdrawn by a non-holder release.
- Flags staying independent across addresses.
- Data bits above bit 0 being ignored.

// File: rtl/sem_pkg.sv
// Shared types for the semaphore bank.
package sem_pkg;
    // Holder of one flag.
    typedef enum logic [1:0] {
        SEM_FREE  = 2'd0,
        SEM_LEFT  = 2'd1,
        SEM_RIGHT = 2'd2
    } sem_owner_e;
endpackage

// File: rtl/sem_cell.sv
// One token flag: holder plus a waiting request from each side.
// Assumes each side issues at most one of req/rel per cycle.
// Left wins a tie on a free flag.
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);
    sem_owner_e owner_q, owner_d, holder;
    logic       l_pend_q, r_pend_q, l_pend_d, r_pend_d;
    logic       l_want, r_want;

    // Next state: apply releases, then grant free flag left first.
    always_comb begin
        l_want = (l_pend_q | l_req) & ~l_rel;
        r_want = (r_pend_q | r_req) & ~r_rel;
        holder = owner_q;
        if (owner_q == SEM_LEFT && l_rel)
            holder = SEM_FREE;
        if (owner_q == SEM_RIGHT && r_rel)
            holder = SEM_FREE;
        owner_d = holder;
        if (holder == SEM_FREE) begin
            if (l_want)
                owner_d = SEM_LEFT;
            else if (r_want)
                owner_d = SEM_RIGHT;
        end
        l_pend_d = l_want && (owner_d != SEM_LEFT);
        r_pend_d = r_want && (owner_d != SEM_RIGHT);
    end

    // State register with synchronous reset to free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= SEM_FREE;
            l_pend_q <= 1'b0;
            r_pend_q <= 1'b0;
        end else begin
            owner_q  <= owner_d;
            l_pend_q <= l_pend_d;
            r_pend_q <= r_pend_d;
        end
    end

    assign own_l  = (owner_q == SEM_LEFT);
    assign own_r  = (owner_q == SEM_RIGHT);
    assign pend_l = l_pend_q;
    assign pend_r = r_pend_q;
endmodule

// File: rtl/sem_port_if.sv
// Per-side access decode.
// Turns the side's strobes into one-hot request/release vectors.
// Drives read data from the side's view of the addressed flag.
// Assumes NUM_SEM fits in ADDR_W bits.
module sem_port_if #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 16
) (
    input  logic               ce_n,
    input  logic               sel_n,
    input  logic               wr_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SEM-1:0] held,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel,
    output logic [DATA_W-1:0]  rdata
);
    logic acc, do_wr, do_rd;

    // Flag access needs the memory enable off and the flag select on.
    always_comb begin
        acc   = ce_n && !sel_n;
        do_wr = acc && !wr_n;
        do_rd = acc && wr_n;
    end

    // One strobe per flag from address and data bit 0.
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
        assign req[i] = do_wr && (addr == ADDR_W'(i)) && !wdata[0];
        assign rel[i] = do_wr && (addr == ADDR_W'(i)) &&  wdata[0];
    end

    // Read view: zeros when this side holds the flag.
    always_comb begin
        rdata = '1;
        if (do_rd && held[addr])
            rdata = '0;
    end
endmodule

// File: rtl/sem_bank.sv
// Bank of NUM_SEM token flags shared by a left and a right side.
// Assumes both sides run on one clock.
module sem_bank #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int ADDR_W = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_sel_n,
    input  logic              l_wr_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_ce_n,
    input  logic              r_sel_n,
    input  logic              r_wr_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_SEM-1:0] own_l, own_r, pend_l, pend_r;

    sem_port_if #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lport (
        .ce_n(l_ce_n), .sel_n(l_sel_n), .wr_n(l_wr_n), .addr(l_addr),
        .wdata(l_wdata), .held(own_l), .req(l_req), .rel(l_rel), .rdata(l_rdata)
    );

    sem_port_if #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rport (
        .ce_n(r_ce_n), .sel_n(r_sel_n), .wr_n(r_wr_n), .addr(r_addr),
        .wdata(r_wdata), .held(own_r), .req(r_req), .rel(r_rel), .rdata(r_rdata)
    );

    // One cell per flag.
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[i]), .l_rel(l_rel[i]),
            .r_req(r_req[i]), .r_rel(r_rel[i]),
            .own_l(own_l[i]), .own_r(own_r[i]),
            .pend_l(pend_l[i]), .pend_r(pend_r[i])
        );
    end
endmodule

// File: rtl/sem_bank_chk.sv
// Checker for sem_bank, bound into every instance.
// Watches the ports and the per-flag holder and waiting vectors.
module sem_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int ADDR_W = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_ce_n,
    input logic               l_sel_n,
    input logic               l_wr_n,
    input logic [ADDR_W-1:0]  l_addr,
    input logic [DATA_W-1:0]  l_wdata,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_ce_n,
    input logic               r_sel_n,
    input logic               r_wr_n,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r,
    input logic [NUM_SEM-1:0] pend_l,
    input logic [NUM_SEM-1:0] pend_r
);
    logic l_write, r_write;
    assign l_write = l_ce_n && !l_sel_n && !l_wr_n;
    assign r_write = r_ce_n && !r_sel_n && !r_wr_n;

    // R12
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    // R6
    owner_not_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_l & pend_l) | (own_r & pend_r)) == '0);

    // R4
    rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    // R2
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_write && !r_write) |=> ($stable(own_l) && $stable(own_r)
                                    && $stable(pend_l) && $stable(pend_r)));

    // R5
    free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_write && !l_wdata[0] && !own_l[l_addr] && !own_r[l_addr])
        |=> own_l[$past(l_addr)]);
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_ce_n(r_ce_n), .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_rdata(r_rdata),
    .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sem_bank_bench.sv
// Directed bench for sem_bank.
// Drives inputs on the falling edge and samples 1 ns later.
module sem_bank_bench;
    localparam logic [15:0] HELD = 16'h0000;
    localparam logic [15:0] NOTH = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_ce_n, l_sel_n, l_wr_n, r_ce_n, r_sel_n, r_wr_n;
    logic [2:0]  l_addr, r_addr;
    logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sem_bank u_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_ce_n(r_ce_n), .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic idle();
        l_ce_n = 1'b0; l_sel_n = 1'b1; l_wr_n = 1'b1; l_addr = '0; l_wdata = '0;
        r_ce_n = 1'b0; r_sel_n = 1'b1; r_wr_n = 1'b1; r_addr = '0; r_wdata = '0;
    endtask

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One write from one side (0 = left), with chosen enables.
    task automatic wr_x(input bit rside, input int a, input logic [15:0] d,
                        input logic ce_n, input logic sel_n);
        @(negedge clk);
        if (!rside) begin
            l_ce_n = ce_n; l_sel_n = sel_n; l_wr_n = 1'b0; l_addr = 3'(a); l_wdata = d;
        end else begin
            r_ce_n = ce_n; r_sel_n = sel_n; r_wr_n = 1'b0; r_addr = 3'(a); r_wdata = d;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input bit rside, input int a, input logic [15:0] d);
        wr_x(rside, a, d, 1'b1, 1'b0);
    endtask

    // Flag read from one side and compare.
    task automatic rd(input bit rside, input int a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        if (!rside) begin
            l_ce_n = 1'b1; l_sel_n = 1'b0; l_wr_n = 1'b1; l_addr = 3'(a);
        end else begin
            r_ce_n = 1'b1; r_sel_n = 1'b0; r_wr_n = 1'b1; r_addr = 3'(a);
        end
        #1;
        check(tag, rside ? r_rdata : l_rdata, exp);
        idle();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) begin
            rd(0, i, NOTH, "R11 left free after reset");
            rd(1, i, NOTH, "R11 right free after reset");
        end
    endtask

    task automatic t_handover();
        wr(0, 5, 16'h0000); rd(0, 5, HELD, "R5 left granted"); rd(1, 5, NOTH, "R4 right view");
        wr(1, 5, 16'h0000); rd(0, 5, HELD, "R6 left keeps"); rd(1, 5, NOTH, "R6 right waits");
        wr(0, 5, 16'h0001); rd(1, 5, HELD, "R7 right takes over"); rd(0, 5, NOTH, "R7 left lost");
        wr(0, 5, 16'h0000); rd(0, 5, NOTH, "R6 left waits");
        wr(1, 5, 16'h0001); rd(0, 5, HELD, "R7 left takes over");
        wr(0, 5, 16'h0001); rd(0, 5, NOTH, "R8 free left"); rd(1, 5, NOTH, "R8 free right");
        wr(1, 5, 16'h0000); rd(1, 5, HELD, "R5 right granted");
        wr(1, 5, 16'h0001); rd(1, 5, NOTH, "R8 right freed");
    endtask

    task automatic t_nonholder();
        wr(0, 1, 16'h0000);
        wr(1, 1, 16'h0000);
        wr(1, 1, 16'h0001);
        rd(0, 1, HELD, "R9 holder unchanged");
        wr(0, 1, 16'h0001);
        rd(1, 1, NOTH, "R9 withdrawn request not granted");
        rd(0, 1, NOTH, "R9 flag free");
    endtask

    task automatic t_tie();
        @(negedge clk);
        l_ce_n = 1'b1; l_sel_n = 1'b0; l_wr_n = 1'b0; l_addr = 3'd3; l_wdata = 16'h0000;
        r_ce_n = 1'b1; r_sel_n = 1'b0; r_wr_n = 1'b0; r_addr = 3'd3; r_wdata = 16'h0000;
        @(negedge clk);
        idle();
        rd(0, 3, HELD, "R10 left wins tie");
        rd(1, 3, NOTH, "R10 right not granted");
        wr(0, 3, 16'h0001);
        rd(1, 3, HELD, "R10 right request was waiting");
        wr(1, 3, 16'h0001);
    endtask

    task automatic t_gating();
        wr_x(0, 2, 16'h0000, 1'b0, 1'b0); rd(0, 2, NOTH, "R2 ce_n low blocks request");
        wr_x(0, 2, 16'h0000, 1'b1, 1'b1); rd(0, 2, NOTH, "R2 sel_n high blocks request");
        wr(0, 2, 16'h0000);
        wr_x(0, 2, 16'h0001, 1'b0, 1'b0); rd(0, 2, HELD, "R2 ce_n low blocks release");
        @(negedge clk);
        l_ce_n = 1'b0; l_sel_n = 1'b0; l_wr_n = 1'b1; l_addr = 3'd2; #1;
        check("R2 no flag read gives all ones", l_rdata, NOTH);
        idle();
        wr(0, 2, 16'h0001);
    endtask

    task automatic t_databits();
        wr(1, 4, 16'hFFFE); rd(1, 4, HELD, "R3 only bit0 requests");
        wr(1, 4, 16'h0001); rd(1, 4, NOTH, "R3 only bit0 releases");
    endtask

    task automatic t_independent();
        wr(0, 6, 16'h0000); wr(1, 7, 16'h0000);
        rd(0, 6, HELD, "R1 left on 6"); rd(1, 7, HELD, "R1 right on 7");
        rd(0, 7, NOTH, "R1 left not on 7"); rd(1, 6, NOTH, "R1 right not on 6");
        rd(0, 0, NOTH, "R1 flag 0 untouched");
        wr(0, 6, 16'h0001); wr(1, 7, 16'h0001);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_handover();
        t_nonholder();
        t_tie();
        t_gating();
        t_databits();
        t_independent();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule